// File: doc/BRIEF.md
# Auto-Incrementing Buffer RAM Access Pointer

This block gives a host microcontroller access to a 2048-byte on-chip buffer RAM through a byte-wide register port with only four register slots. The host loads an 11-bit pointer through two pointer registers. It then moves bytes through a single data register, and each data access goes to the RAM location the pointer holds. Two flag bits stored next to the upper address bits set the direction of the coming data accesses and whether the pointer steps forward after each one.

In read direction the block fetches ahead. Writing the low pointer byte loads the byte at the new address into the RAM's output register. Each data read returns that byte and fetches the next one. Reads can therefore run back to back, one per clock, with no wait state. The RAM is a single-port synchronous array inside the block.

The host strobes are one clock wide. A write strobe has priority over a read strobe in the same cycle. The read data is a combinational function of the register slot selected in that cycle.

Top module: `ram_ptr_port`

## Requirements
- R1: After reset the pointer is 0x000, the direction is write and auto-increment is off. The data slot reads 0x00.
- R2: Slot 1 (pointer high) is laid out as follows. Bit 7 is the direction flag (1 = read, 0 = write). Bit 6 is the auto-increment flag. Bits 2..0 are pointer bits 10..8. Bits 5..3 read as 0, whatever was written to them.
- R3: Slot 2 (pointer low) holds pointer bits 7..0. A write replaces them and a read returns them. Pointer bits 10..8 are not changed.
- R4: In write direction, a data write (slot 0) stores the written byte in the RAM at the current pointer.
- R5: With auto-increment on, every accepted data access advances the pointer by one. With it off, the pointer stays unchanged.
- R6: Advancing from 0x7FF gives 0x000.
- R7: A pointer-low write in read direction fetches the byte at the new address. A data read in any later cycle returns it.
- R8: In read direction, a data read returns the byte at the current pointer and fetches the byte at the following pointer value. Back-to-back reads, one per clock, return consecutive bytes.
- R9: A data write in read direction leaves both the RAM and the pointer unchanged. A data read in write direction does the same.
- R10: The slot select is 0 = data, 1 = pointer high, 2 = pointer low. Slot 3 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 2 | Register slot select |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected slot |

## Verification
The tests cover these input patterns:
- A block of bytes is written with auto-increment on, then read back as a back-to-back burst. This separates a correct fetch-ahead from a stale or off-by-one output register.
- A run starting at 0x7FC crosses the top of the address range, in both directions. This shows whether the pointer wraps to 0x000 or spills into bit 11.
- Repeated data reads are made with auto-increment off. These must return the same byte while the pointer stays put.
- Data accesses are made against the stored direction. These must move neither the pointer nor any RAM byte, which a later read of the same location confirms.

// File: rtl/ram_ptr_pkg.sv
package ram_ptr_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int FLAG_RD_BIT  = 7;
  localparam int FLAG_INC_BIT = 6;

endpackage

// File: rtl/ram_ptr_sp_ram.sv
module ram_ptr_sp_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/ram_ptr_regs.sv
module ram_ptr_regs #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic            hi_rd,
  input  logic            hi_inc,
  input  logic [AW-DW-1:0] hi_addr,
  input  logic [DW-1:0]   lo_byte,
  input  logic            advance,
  output logic [AW-1:0]   ptr,
  output logic            rd_flag,
  output logic            inc_flag,
  output logic [AW-1:0]   lo_next,
  output logic [AW-1:0]   step_ptr
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic en);
    return en ? p + AW'(1) : p;
  endfunction

  assign lo_next  = {ptr[AW-1:DW], lo_byte};
  assign step_ptr = bump(ptr, inc_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      rd_flag  <= 1'b0;
      inc_flag <= 1'b0;
    end else begin
      if (wr_hi) begin
        rd_flag         <= hi_rd;
        inc_flag        <= hi_inc;
        ptr[AW-1:DW]    <= hi_addr;
      end else if (wr_lo) begin
        ptr[DW-1:0]     <= lo_byte;
      end else if (advance) begin
        ptr             <= step_ptr;
      end
    end
  end
endmodule

// File: rtl/ram_ptr_port.sv
module ram_ptr_port #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  import ram_ptr_pkg::*;

  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int PAD_W = DATA_W - 2 - HI_W;

  reg_sel_e sel;
  assign sel = reg_sel_e'(host_sel);

  logic [ADDR_W-1:0] ptr, lo_next, step_ptr, ram_addr;
  logic              rd_flag, inc_flag;
  logic [DATA_W-1:0] ram_q;

  // named events for the checker
  logic ev_data_wr_ok, ev_data_rd_ok, ev_ptr_lo_wr, ev_ptr_hi_wr;
  logic ev_prefetch_lo, advance, ram_we, ram_re;

  assign ev_ptr_hi_wr   = host_wr && sel == SEL_HI;
  assign ev_ptr_lo_wr   = host_wr && sel == SEL_LO;
  assign ev_data_wr_ok  = host_wr && sel == SEL_DATA && !rd_flag;
  assign ev_data_rd_ok  = host_rd && !host_wr && sel == SEL_DATA && rd_flag;
  assign ev_prefetch_lo = ev_ptr_lo_wr && rd_flag;
  assign advance        = (ev_data_wr_ok || ev_data_rd_ok) && inc_flag;
  assign ram_we         = ev_data_wr_ok;
  assign ram_re         = ev_prefetch_lo || ev_data_rd_ok;

  always_comb begin
    if (ev_prefetch_lo)     ram_addr = lo_next;
    else if (ev_data_rd_ok) ram_addr = step_ptr;
    else                    ram_addr = ptr;
  end

  ram_ptr_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hi    (ev_ptr_hi_wr),
    .wr_lo    (ev_ptr_lo_wr),
    .hi_rd    (host_wdata[FLAG_RD_BIT]),
    .hi_inc   (host_wdata[FLAG_INC_BIT]),
    .hi_addr  (host_wdata[HI_W-1:0]),
    .lo_byte  (host_wdata),
    .advance  (advance),
    .ptr      (ptr),
    .rd_flag  (rd_flag),
    .inc_flag (inc_flag),
    .lo_next  (lo_next),
    .step_ptr (step_ptr)
  );

  ram_ptr_sp_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (host_wdata),
    .rdata (ram_q)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: host_rdata = ram_q;
      SEL_HI:   host_rdata = {rd_flag, inc_flag, {PAD_W{1'b0}}, ptr[ADDR_W-1:DATA_W]};
      SEL_LO:   host_rdata = ptr[DATA_W-1:0];
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ram_ptr_port_chk.sv
module ram_ptr_port_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        host_sel,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_rdata,
  input logic [ADDR_W-1:0] ptr,
  input logic              rd_flag,
  input logic              inc_flag,
  input logic              ev_data_wr_ok,
  input logic              ev_data_rd_ok,
  input logic              ram_we,
  input logic              ram_re
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel == 2'd1 |-> host_rdata[5:3] == 3'b000);

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_wr_ok || ev_data_rd_ok) && !inc_flag |=> $stable(ptr));

  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_wr_ok || ev_data_rd_ok) && inc_flag && (&ptr) |=> ptr == '0);

  assert_prefetch_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd2 && rd_flag |-> ram_re);

  assert_read_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && host_sel == 2'd0 && rd_flag |-> ram_re && !ram_we);

  assert_no_wrongdir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd0 && rd_flag |-> !ram_we);

  assert_wrongdir_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && host_sel == 2'd0 && !rd_flag |=> $stable(ptr));
endmodule

bind ram_ptr_port ram_ptr_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_sel      (host_sel),
  .host_wr       (host_wr),
  .host_rd       (host_rd),
  .host_rdata    (host_rdata),
  .ptr           (ptr),
  .rd_flag       (rd_flag),
  .inc_flag      (inc_flag),
  .ev_data_wr_ok (ev_data_wr_ok),
  .ev_data_rd_ok (ev_data_rd_ok),
  .ram_we        (ram_we),
  .ram_re        (ram_re)
);

// File: tb/ram_ptr_port_tb.sv
module ram_ptr_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  ram_ptr_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  // behavioural reference: -1 marks a byte never written
  int mem [DEPTH];
  int m_ptr, m_hold;
  bit m_rd, m_inc;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  function automatic int model_read(input int sel);
    case (sel)
      0: return m_hold;
      1: return (int'(m_rd) << 7) | (int'(m_inc) << 6) | (m_ptr >> 8);
      2: return m_ptr & 255;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(input int sel, input bit w, input bit r, input int d);
    if (w) begin
      if (sel == 1) begin
        m_rd = d[7]; m_inc = d[6];
        m_ptr = ((d & 7) << 8) | (m_ptr & 255);
      end else if (sel == 2) begin
        m_ptr = (m_ptr & 'h700) | d;
        if (m_rd) m_hold = mem[m_ptr];
      end else if (sel == 0 && !m_rd) begin
        mem[m_ptr] = d;
        if (m_inc) m_ptr = (m_ptr + 1) % DEPTH;
      end
    end else if (r && sel == 0 && m_rd) begin
      if (m_inc) m_ptr = (m_ptr + 1) % DEPTH;
      m_hold = mem[m_ptr];
    end
  endtask

  // one bus cycle: drive, compare against the model, advance the model
  task automatic cyc(input int sel, input bit w, input bit r, input int d, input string req);
    int exp;
    @(negedge clk);
    host_sel = 2'(sel); host_wr = w; host_rd = r; host_wdata = 8'(d);
    #1;
    exp = model_read(sel);
    if (exp >= 0) begin
      n_vec++;
      if (int'(host_rdata) != exp) begin
        n_bad++;
        $display("FAIL %s: slot %0d actual 0x%02h expected 0x%02h", req, sel, host_rdata, exp);
      end
    end
    model_step(sel, w, r, d);
  endtask

  task automatic peek(input int sel, input string req);
    cyc(sel, 0, 0, 0, req);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = -1;
    m_ptr = 0; m_hold = 0; m_rd = 0; m_inc = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 / R10 reset state and slot map
    peek(1, "R1"); peek(2, "R1"); peek(0, "R1"); peek(3, "R10");

    // R2 reserved bits ignored; R3 low byte leaves high bits alone
    cyc(1, 1, 0, 'h3F, "R2"); peek(1, "R2");
    cyc(2, 1, 0, 'h5A, "R3"); peek(2, "R3"); peek(1, "R3");

    // R4 R5 R6 write burst across the top of the range
    cyc(1, 1, 0, 'h47, "R5"); cyc(2, 1, 0, 'hFC, "R6");
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, 'h30 + i, "R4");
    peek(2, "R6"); peek(1, "R6");

    // R4 block write at 0x100
    cyc(1, 1, 0, 'h41, "R4"); cyc(2, 1, 0, 'h00, "R4");
    for (int i = 0; i < 16; i++) cyc(0, 1, 0, (i * 37 + 5) & 255, "R4");

    // R7 R8 read back-to-back, including wrap
    cyc(1, 1, 0, 'hC7, "R7"); cyc(2, 1, 0, 'hFC, "R7");
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, "R8");
    peek(2, "R6");
    cyc(1, 1, 0, 'hC1, "R7"); cyc(2, 1, 0, 'h00, "R7");
    for (int i = 0; i < 16; i++) cyc(0, 0, 1, 0, "R8");

    // R5 auto-increment off: same byte, pointer fixed
    cyc(1, 1, 0, 'h81, "R5"); cyc(2, 1, 0, 'h03, "R7"); peek(0, "R7");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, "R5");
    peek(2, "R5");

    // R9 data write in read direction
    cyc(1, 1, 0, 'hC1, "R9"); cyc(2, 1, 0, 'h05, "R9");
    cyc(0, 1, 0, 'hAA, "R9"); peek(2, "R9");
    cyc(2, 1, 0, 'h05, "R9"); cyc(0, 0, 1, 0, "R9");

    // R9 data read in write direction
    cyc(1, 1, 0, 'h41, "R9"); cyc(2, 1, 0, 'h10, "R9");
    cyc(0, 0, 1, 0, "R9"); peek(2, "R9");
    cyc(0, 1, 0, 'h99, "R9");
    cyc(1, 1, 0, 'hC1, "R9"); cyc(2, 1, 0, 'h0F, "R9");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, "R9");
    peek(3, "R10");

    @(negedge clk);
    host_wr = 0; host_rd = 0;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule